// File: doc/BRIEF.md
# Receive/Transmit Interrupt Status and Mask Unit

This unit collects three events from the FIFO logic of a serial frame controller. The controller has 32-byte receive and transmit FIFOs. The three events are: a frame (or the final part of a long frame) is complete in the receive FIFO, a 32-byte block of an unfinished frame is waiting in the receive FIFO, and the transmit FIFO has room for up to 32 more bytes. Each event sets a sticky status bit. Each status bit is paired with a mask bit. The single interrupt output is high while any status bit is set and its mask bit is clear.

Software reaches both registers through a small register port. A read of the status register returns its contents and clears every bit that was set at that moment. An event that lands in the same cycle as the read is kept for the next read.

The operating mode changes how events are qualified. With DMA operation selected, the two pool events are dropped, and a frame-complete event is held back until the DMA engine reports that its transfer finished. A frame-complete event that comes together with the auto-mode extended-frame indication is discarded in every mode.

Top module: `isr_unit`

## Requirements
- R1: After a synchronous active-low reset, the status register, the mask register, the read data and `irq` are all zero, so every interrupt is enabled.
- R2: With `dma_mode` low, `ev_msg_end` sets status bit 7, `ev_pool_full` sets status bit 6 and `ev_tx_ready` sets status bit 4. Each bit is set at the clock edge where its pulse is sampled. All other status bits read 0.
- R3: A read sets `reg_rd` for one cycle. The address is 0 for status and 1 for mask. The read data appears after that clock edge and holds until the next read. A status read clears the bits that were set before the read edge, and it keeps any event sampled at the same edge.
- R4: A write with `reg_addr` 1 loads the mask from `reg_wdata` bits 7, 6 and 4. The mask reads back with all other bits at 0.
- R5: `irq` is high exactly while some status bit is 1 and the mask bit at the same position is 0. A mask bit of 1 keeps its event recorded in the status register but stops it from driving `irq`.
- R6: With `dma_mode` high, `ev_pool_full` and `ev_tx_ready` set no status bit and raise no interrupt.
- R7: With `dma_mode` high, `ev_msg_end` does not set bit 7 at once. Bit 7 is set at the first `dma_done` pulse that follows it. A `dma_done` pulse with no deferred frame end has no effect.
- R8: An `ev_msg_end` pulse sampled together with `ext_frame` sets no status bit, in both modes.
- R9: A write to the status address (0) leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_msg_end | input | 1 | One-cycle pulse: frame or last frame part complete in receive FIFO |
| ev_pool_full | input | 1 | One-cycle pulse: 32-byte block of an unfinished frame stored |
| ev_tx_ready | input | 1 | One-cycle pulse: transmit FIFO can accept up to 32 bytes |
| ext_frame | input | 1 | Auto mode has recognised an extended frame (qualifies `ev_msg_end`) |
| dma_mode | input | 1 | High selects DMA operation |
| dma_done | input | 1 | One-cycle pulse: DMA transfer finished correctly |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects mask |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, active high |

## Verification
The properties assume that the event inputs and `dma_done` are single-cycle pulses. They also assume that `reg_rd` and `reg_wr` are never high in the same cycle, and that `dma_mode` changes only while no frame end is deferred. The bench drives every stimulus from a task that raises a strobe for exactly one cycle at a falling edge and clears it afterwards. It never overlaps a read with a write, and it switches `dma_mode` only after each deferred frame end has been released by `dma_done`. Where a read and an event must coincide, the bench raises the event pulse in the same driver cycle as the read strobe. The read-clear property therefore allows for a new event arriving at the read edge.

// File: rtl/isr_pkg.sv
// Package: shared constants for the interrupt status/mask unit.
// Assumes an 8-bit register port; event index order is frame end,
// pool full, transmit ready.
package isr_pkg;

    localparam int unsigned REG_W  = 8;
    localparam int unsigned NUM_EV = 3;

    // Event indices inside the internal event vectors.
    localparam int unsigned EV_MSG_END   = 0;
    localparam int unsigned EV_POOL_FULL = 1;
    localparam int unsigned EV_TX_READY  = 2;

    // Register bit positions seen by software.
    localparam int unsigned POS_MSG_END   = 7;
    localparam int unsigned POS_POOL_FULL = 6;
    localparam int unsigned POS_TX_READY  = 4;

    localparam logic [REG_W-1:0] IMPL_BITS =
        (REG_W'(1) << POS_MSG_END) | (REG_W'(1) << POS_POOL_FULL) |
        (REG_W'(1) << POS_TX_READY);

    typedef enum logic [0:0] {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

    // Map an event index to its register bit position.
    function automatic int unsigned ev_pos(input int unsigned idx);
        case (idx)
            EV_MSG_END:   ev_pos = POS_MSG_END;
            EV_POOL_FULL: ev_pos = POS_POOL_FULL;
            default:      ev_pos = POS_TX_READY;
        endcase
    endfunction

endpackage

// File: rtl/isr_event_gate.sv
// Module: qualifies raw FIFO events by operating mode.
// Non-DMA: events pass straight through (frame end dropped on extended frame).
// DMA: pool events dropped; frame end parked until dma_done.
// Assumes single-cycle event pulses.
module isr_event_gate
    import isr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_msg_end,
    input  logic              ev_pool_full,
    input  logic              ev_tx_ready,
    input  logic              ext_frame,
    input  logic              dma_mode,
    input  logic              dma_done,
    output logic [NUM_EV-1:0] set_vec
);

    logic msg_ok;
    logic park_q;
    logic release_now;

    // Frame end counts only when no extended frame was recognised.
    always_comb msg_ok = ev_msg_end & ~ext_frame;

    // A parked frame end is released by the DMA completion pulse.
    always_comb release_now = park_q & dma_done;

    // Track a frame end deferred until the DMA transfer completes.
    always_ff @(posedge clk) begin
        if (!rst_n || !dma_mode) begin
            park_q <= 1'b0;
        end else begin
            park_q <= (park_q & ~dma_done) | msg_ok;
        end
    end

    // Build the per-event set vector for the status register.
    always_comb begin
        set_vec               = '0;
        set_vec[EV_MSG_END]   = dma_mode ? release_now : msg_ok;
        set_vec[EV_POOL_FULL] = ~dma_mode & ev_pool_full;
        set_vec[EV_TX_READY]  = ~dma_mode & ev_tx_ready;
    end

endmodule

// File: rtl/isr_status_reg.sv
// Module: sticky status flags with clear-on-read.
// A read clears flags set before the edge; a set at the same edge survives.
module isr_status_reg
    import isr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] set_vec,
    input  logic              rd_clr,
    output logic [NUM_EV-1:0] flags_q
);

    for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
        // One sticky flag per event.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q[i] <= 1'b0;
            end else begin
                flags_q[i] <= set_vec[i] | (flags_q[i] & ~rd_clr);
            end
        end
    end

endmodule

// File: rtl/isr_mask_reg.sv
// Module: per-event mask bits loaded from the register port.
// A 1 disables the matching interrupt; reset value enables all.
module isr_mask_reg
    import isr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    output logic [NUM_EV-1:0] mask_q
);

    logic unused_wdata;
    always_comb unused_wdata = ^(wdata & ~IMPL_BITS);

    for (genvar i = 0; i < NUM_EV; i++) begin : g_mask
        // Capture the mask bit at this event's register position.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[i] <= 1'b0;
            end else if (wr_en) begin
                mask_q[i] <= wdata[ev_pos(i)];
            end
        end
    end

endmodule

// File: rtl/isr_unit.sv
// Module: interrupt status and mask unit (top).
// Holds status and mask registers, decodes the register port and drives irq.
// Assumes reg_rd and reg_wr are not asserted together.
module isr_unit
    import isr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_msg_end,
    input  logic             ev_pool_full,
    input  logic             ev_tx_ready,
    input  logic             ext_frame,
    input  logic             dma_mode,
    input  logic             dma_done,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);

    logic [NUM_EV-1:0] set_vec;
    logic [NUM_EV-1:0] flags;
    logic [NUM_EV-1:0] mask;
    logic              rd_status;
    logic              wr_mask;
    logic [REG_W-1:0]  status_word;
    logic [REG_W-1:0]  mask_word;
    reg_sel_e          sel;

    // Decode the register port.
    always_comb begin
        sel       = reg_sel_e'(reg_addr);
        rd_status = reg_rd & (sel == SEL_STATUS);
        wr_mask   = reg_wr & (sel == SEL_MASK);
    end

    isr_event_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_msg_end   (ev_msg_end),
        .ev_pool_full (ev_pool_full),
        .ev_tx_ready  (ev_tx_ready),
        .ext_frame    (ext_frame),
        .dma_mode     (dma_mode),
        .dma_done     (dma_done),
        .set_vec      (set_vec)
    );

    isr_status_reg u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .rd_clr  (rd_status),
        .flags_q (flags)
    );

    isr_mask_reg u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_mask),
        .wdata  (reg_wdata),
        .mask_q (mask)
    );

    // Spread event flags and masks onto their register bit positions.
    always_comb begin
        status_word = '0;
        mask_word   = '0;
        for (int i = 0; i < NUM_EV; i++) begin
            status_word[ev_pos(i)] = flags[i];
            mask_word[ev_pos(i)]   = mask[i];
        end
    end

    // Register the read data on every read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= (sel == SEL_MASK) ? mask_word : status_word;
        end
    end

    // Interrupt: any recorded event whose mask bit is clear.
    always_comb irq = |(flags & ~mask);

endmodule

// File: rtl/isr_unit_chk.sv
// Module: property checker for isr_unit, attached with bind.
module isr_unit_chk
    import isr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ev_msg_end,
    input logic             ev_pool_full,
    input logic             ev_tx_ready,
    input logic             ext_frame,
    input logic             dma_mode,
    input logic             dma_done,
    input logic             reg_rd,
    input logic             reg_wr,
    input logic             reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             irq,
    input logic [REG_W-1:0] status_word,
    input logic [REG_W-1:0] mask_word
);

    logic no_ev;
    always_comb no_ev = !ev_msg_end && !ev_pool_full && !ev_tx_ready && !dma_done;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (status_word == '0 && mask_word == '0 && !irq && reg_rdata == '0));

    // R3
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_addr && no_ev) |=> status_word == '0);

    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr) |=> mask_word == ($past(reg_wdata) & IMPL_BITS));

    // R4
    mask_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr && !reg_wr) |=> reg_rdata == $past(mask_word));

    // R5
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_ready && !dma_mode && !mask_word[POS_TX_READY] && !reg_wr) |=> irq);

    // R6
    dma_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode && !status_word[POS_POOL_FULL] && !status_word[POS_TX_READY])
            |=> (!status_word[POS_POOL_FULL] && !status_word[POS_TX_READY]));

    // R7
    dma_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode && ev_msg_end && !dma_done && !status_word[POS_MSG_END])
            |=> !status_word[POS_MSG_END]);

    // R8
    ext_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_mode && ev_msg_end && ext_frame && !status_word[POS_MSG_END])
            |=> !status_word[POS_MSG_END]);

    // R9
    status_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr && !reg_rd && no_ev) |=> $stable(status_word));

endmodule

bind isr_unit isr_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_msg_end   (ev_msg_end),
    .ev_pool_full (ev_pool_full),
    .ev_tx_ready  (ev_tx_ready),
    .ext_frame    (ext_frame),
    .dma_mode     (dma_mode),
    .dma_done     (dma_done),
    .reg_rd       (reg_rd),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .irq          (irq),
    .status_word  (status_word),
    .mask_word    (mask_word)
);

// File: tb/isr_unit_test.sv
`timescale 1ns/1ps
module isr_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_msg_end = 1'b0, ev_pool_full = 1'b0, ev_tx_ready = 1'b0;
    logic       ext_frame = 1'b0, dma_mode = 1'b0, dma_done = 1'b0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    logic chk_due = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    isr_unit uut (
        .clk (clk), .rst_n (rst_n),
        .ev_msg_end (ev_msg_end), .ev_pool_full (ev_pool_full),
        .ev_tx_ready (ev_tx_ready), .ext_frame (ext_frame),
        .dma_mode (dma_mode), .dma_done (dma_done),
        .reg_rd (reg_rd), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq (irq)
    );

    // Monitor: note a read at the edge, compare its data at the next falling edge.
    always @(posedge clk) chk_due <= reg_rd;

    always @(negedge clk) begin
        if (chk_due && exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (reg_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata actual %02h expected %02h", t, reg_rdata, e);
            end
        end
    end

    // Driver tasks: all start and end at a falling edge.
    task automatic step(input logic me, input logic pf, input logic tr,
                        input logic ext, input logic dd);
        ev_msg_end = me; ev_pool_full = pf; ev_tx_ready = tr;
        ext_frame = ext; dma_done = dd;
        @(negedge clk);
        ev_msg_end = 0; ev_pool_full = 0; ev_tx_ready = 0;
        ext_frame = 0; dma_done = 0;
    endtask

    task automatic rd(input logic addr, input logic [7:0] exp, input string tag);
        reg_rd = 1'b1; reg_addr = addr;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0; ev_pool_full = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic addr, input logic [7:0] data);
        reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        n_chk++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s: irq actual %b expected %b", tag, irq, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_irq(1'b0, "R1 irq after reset");
        rd(1'b0, 8'h00, "R1 status after reset");
        rd(1'b1, 8'h00, "R1 mask after reset");

        // Non-DMA event recording and clear-on-read
        step(0, 0, 1, 0, 0);
        chk_irq(1'b1, "R5 tx ready unmasked");
        rd(1'b0, 8'h10, "R2 tx ready bit 4");
        chk_irq(1'b0, "R3 irq after clearing read");
        step(1, 1, 0, 0, 0);
        rd(1'b0, 8'hC0, "R2 frame end and pool full");
        rd(1'b0, 8'h00, "R3 cleared by read");

        // Event coinciding with a read is kept
        step(0, 0, 1, 0, 0);
        ev_pool_full = 1'b1;
        rd(1'b0, 8'h10, "R3 read with concurrent event");
        rd(1'b0, 8'h40, "R3 concurrent event kept");

        // Masking
        wr(1'b1, 8'hFF);
        rd(1'b1, 8'hD0, "R4 mask readback");
        step(0, 0, 1, 0, 0);
        chk_irq(1'b0, "R5 masked tx ready");
        rd(1'b0, 8'h10, "R5 masked event still recorded");
        wr(1'b1, 8'hEF);
        rd(1'b1, 8'hC0, "R4 partial mask");
        step(0, 1, 0, 0, 0);
        chk_irq(1'b0, "R5 masked pool full");
        step(0, 0, 1, 0, 0);
        chk_irq(1'b1, "R5 enabled tx ready");
        rd(1'b0, 8'h50, "R5 both recorded");
        wr(1'b1, 8'h00);

        // Status writes ignored
        step(0, 0, 1, 0, 0);
        wr(1'b0, 8'h00);
        rd(1'b0, 8'h10, "R9 write zero ignored");
        wr(1'b0, 8'hFF);
        rd(1'b0, 8'h00, "R9 write ones ignored");

        // Extended frame in non-DMA mode
        step(1, 0, 0, 1, 0);
        chk_irq(1'b0, "R8 extended frame no irq");
        rd(1'b0, 8'h00, "R8 extended frame no status");

        // DMA mode
        dma_mode = 1'b1;
        @(negedge clk);
        step(0, 1, 1, 0, 0);
        chk_irq(1'b0, "R6 pool events in DMA");
        rd(1'b0, 8'h00, "R6 pool events dropped");
        step(1, 0, 0, 0, 0);
        chk_irq(1'b0, "R7 frame end deferred irq");
        rd(1'b0, 8'h00, "R7 frame end deferred status");
        step(0, 0, 0, 0, 1);
        chk_irq(1'b1, "R7 released by dma done");
        rd(1'b0, 8'h80, "R7 frame end after dma done");
        step(0, 0, 0, 0, 1);
        rd(1'b0, 8'h00, "R7 lone dma done");
        step(1, 0, 0, 1, 0);
        step(0, 0, 0, 0, 1);
        rd(1'b0, 8'h00, "R8 extended frame in DMA");
        dma_mode = 1'b0;
        @(negedge clk);

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule